// File: doc/BRIEF.md
# Serial Shift Register with Flag-Steered Dual Holding Registers

This block takes a serial bit stream into a 25-bit shift register and copies its contents into one of two 24-bit parallel holding registers. The stream's clock and latch strobe are sampled in the system clock domain. A rising edge on the shift clock moves the register up by one place. The new bit from the serial input enters at bit 0, and bit 24 is sent out on the serial output so that several blocks can be chained.

A rising edge on the latch strobe transfers bits 23..0 of the shift register. Bit 24 acts as a destination flag. When it is 0, the bits go to the channel-enable register, which drives one output-enable line for each of 24 current-sink channels. When it is 1, the bits go to the configuration register. One serial frame therefore writes either register, and the register that is not chosen keeps its value.

A small controller has three states. ST_WAIT idles. ST_SHIFT performs one shift. ST_LOAD performs one transfer. The same transitions apply from every state. A latch rise goes to ST_LOAD. A shift-clock rise with no latch rise goes to ST_SHIFT. Any other cycle goes to ST_WAIT. Synchronous reset forces ST_WAIT.

Top module: `dual_latch_shifter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the shift register, the channel-enable register and the configuration register to zero. Every channel is then off and sout is 0.
- R2: Each rising edge of sclk shifts the register by exactly one place, taking sin into bit 0. A level held high for many cycles causes only one shift, and a falling edge causes none.
- R3: sout always shows shift-register bit 24. This is the bit that was shifted in 25 sclk edges earlier.
- R4: On a rising edge of lat with bit 24 equal to 0, chan_en takes bits 23..0 and ctrl_q is unchanged.
- R5: On a rising edge of lat with bit 24 equal to 1, ctrl_q takes bits 23..0 and chan_en is unchanged.
- R6: Holding lat high does not cause further transfers. Bits shifted in while lat stays high reach neither register until the next rising edge of lat.
- R7: If lat and sclk rise in the same cycle, the transfer happens and that sclk edge is dropped, so the shift register is left unchanged.
- R8: chan_en bit n enables channel n, and 1 means on. The last bit shifted before the strobe lands in bit 0 and the first data bit lands in bit 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sin | input | 1 | Serial data input |
| sclk | input | 1 | Shift clock, rising-edge detected |
| lat | input | 1 | Latch strobe, rising-edge detected |
| sout | output | 1 | Serial data output (bit 24) for chaining |
| chan_en | output | 24 | Channel enables, bit n for channel n |
| ctrl_q | output | 24 | Configuration register |

## Verification
The bench builds the block with its default channel width of 24, which gives the 25-bit register and the full frame length. This lets it check the destination flag at bit 24 and the channel mapping at bits 0 and 23. Long level holds on both strobes and a cycle in which both strobes rise together are within reach. A 24-bit drain of the register checks the serial-output order bit by bit.

// File: rtl/dls_pkg.sv
package dls_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/dls_rise_det.sv
module dls_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise
);
    logic d_prev;

    always_ff @(posedge clk) begin
        d_prev <= d;
    end

    assign rise = d & ~d_prev & ~rst;
endmodule

// File: rtl/dls_shift_chain.sv
module dls_shift_chain #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (shift)
            q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/dls_hold_bank.sv
module dls_hold_bank #(
    parameter int W  = 24,
    parameter int NB = 2,
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SEL_W-1:0]    sel,
    input  logic [W-1:0]        din,
    output logic [NB-1:0][W-1:0] q
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                q[b] <= '0;
            else if (load && (sel == SEL_W'(b)))
                q[b] <= din;
        end
    end
endmodule

// File: rtl/dual_latch_shifter.sv
module dual_latch_shifter
    import dls_pkg::*;
#(
    parameter int CHAN_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sin,
    input  logic              sclk,
    input  logic              lat,
    output logic              sout,
    output logic [CHAN_W-1:0] chan_en,
    output logic [CHAN_W-1:0] ctrl_q
);
    localparam int SR_W = CHAN_W + 1;
    localparam int NB   = 2;

    ctl_state_t state, state_nx;
    logic sclk_rise, lat_rise;
    logic shift_go, load_go;
    logic [SR_W-1:0] shreg;
    logic [NB-1:0][CHAN_W-1:0] banks;

    dls_rise_det u_sclk_det (.clk(clk), .rst(rst), .d(sclk), .rise(sclk_rise));
    dls_rise_det u_lat_det  (.clk(clk), .rst(rst), .d(lat),  .rise(lat_rise));

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_WAIT;
        else
            state <= state_nx;
    end

    // Next-state logic: strobe has priority over shift clock
    always_comb begin
        state_nx = ST_WAIT;
        unique case (state)
            ST_WAIT, ST_SHIFT, ST_LOAD: begin
                if (lat_rise)
                    state_nx = ST_LOAD;
                else if (sclk_rise)
                    state_nx = ST_SHIFT;
                else
                    state_nx = ST_WAIT;
            end
            default: state_nx = ST_WAIT;
        endcase
    end

    // Output decode of the controller
    always_comb begin
        shift_go = 1'b0;
        load_go  = 1'b0;
        unique case (state)
            ST_WAIT:  ;
            ST_SHIFT: shift_go = 1'b1;
            ST_LOAD:  load_go  = 1'b1;
            default:  ;
        endcase
    end

    dls_shift_chain #(.W(SR_W)) u_chain (
        .clk(clk), .rst(rst), .shift(shift_go), .din(sin), .q(shreg)
    );

    dls_hold_bank #(.W(CHAN_W), .NB(NB)) u_banks (
        .clk(clk), .rst(rst), .load(load_go),
        .sel(shreg[SR_W-1]), .din(shreg[CHAN_W-1:0]), .q(banks)
    );

    assign chan_en = banks[0];
    assign ctrl_q  = banks[1];
    assign sout    = shreg[SR_W-1];

    // R1: reset clears all storage
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (shreg == '0 && chan_en == '0 && ctrl_q == '0));

    // R2: one shift moves the chain up and inserts sin
    a_r2_shift_step: assert property (@(posedge clk) disable iff (rst)
        shift_go |=> (shreg == {$past(shreg[SR_W-2:0]), $past(sin)}));

    // R4: flag 0 writes channel enables only
    a_r4_load_enable: assert property (@(posedge clk) disable iff (rst)
        (load_go && !shreg[SR_W-1]) |=>
            (chan_en == $past(shreg[CHAN_W-1:0])) && $stable(ctrl_q));

    // R5: flag 1 writes configuration only
    a_r5_load_config: assert property (@(posedge clk) disable iff (rst)
        (load_go && shreg[SR_W-1]) |=>
            (ctrl_q == $past(shreg[CHAN_W-1:0])) && $stable(chan_en));

    // R6: without a transfer both holding registers stay put
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        !load_go |=> ($stable(chan_en) && $stable(ctrl_q)));

    // R7: a transfer cycle never shifts
    a_r7_load_no_shift: assert property (@(posedge clk) disable iff (rst)
        load_go |=> $stable(shreg));
endmodule

// File: tb/dual_latch_shifter_tb_top.sv
module dual_latch_shifter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 24;
    localparam int NV = 6;
    localparam logic [24:0] VEC [0:NV-1] = '{
        25'h0A5A5A5, 25'h1C3C3C3, 25'h0000001,
        25'h1800000, 25'h0800000, 25'h1FFFFFF
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sin = 1'b0, sclk = 1'b0, lat = 1'b0;
    logic sout;
    logic [CW-1:0] chan_en, ctrl_q;
    logic [CW-1:0] exp_on = '0, exp_cfg = '0;
    int checks = 0, errors = 0;

    dual_latch_shifter #(.CHAN_W(CW)) dut_i (
        .clk(clk), .rst(rst), .sin(sin), .sclk(sclk), .lat(lat),
        .sout(sout), .chan_en(chan_en), .ctrl_q(ctrl_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        sin = b; sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic put_word(input logic [24:0] w);
        for (int i = 24; i >= 0; i--) put_bit(w[i]);
    endtask

    task automatic strobe();
        @(negedge clk);
        lat = 1'b1;
        repeat (3) @(negedge clk);
        lat = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset chan_en", 32'(chan_en), 32'h0);
        chk("R1 reset ctrl_q", 32'(ctrl_q), 32'h0);
        chk("R1 reset sout", 32'(sout), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Table-driven frames: R3, R4, R5, R8
        for (int v = 0; v < NV; v++) begin
            put_word(VEC[v]);
            chk("R3 sout shows flag bit", 32'(sout), 32'(VEC[v][24]));
            strobe();
            if (VEC[v][24]) exp_cfg = VEC[v][23:0];
            else exp_on = VEC[v][23:0];
            chk("R4 R8 chan_en after frame", 32'(chan_en), 32'(exp_on));
            chk("R5 ctrl_q after frame", 32'(ctrl_q), 32'(exp_cfg));
        end

        // R2 R3: drain order of the serial output
        put_word(25'h0B3C5A7);
        for (int k = 1; k <= 24; k++) begin
            put_bit(1'b0);
            chk("R2 R3 drain order", 32'(sout), 32'(25'h0B3C5A7 >> (24 - k)) & 32'h1);
        end
        strobe();
        exp_cfg = '0;
        chk("R5 drained frame to config", 32'(ctrl_q), 32'h0);
        chk("R4 drained frame leaves enables", 32'(chan_en), 32'(exp_on));

        // R2: long sclk level gives one shift only
        put_word(25'h0000000);
        @(negedge clk);
        sin = 1'b1; sclk = 1'b1;
        repeat (20) @(negedge clk);
        sclk = 1'b0;
        repeat (20) @(negedge clk);
        for (int k = 0; k < 23; k++) put_bit(1'b0);
        chk("R2 long level before last shift", 32'(sout), 32'h0);
        put_bit(1'b0);
        chk("R2 long level single shift", 32'(sout), 32'h1);

        // R6: lat held high
        put_word(25'h0111111);
        @(negedge clk);
        lat = 1'b1;
        repeat (3) @(negedge clk);
        exp_on = 24'h111111;
        chk("R6 first rise loads", 32'(chan_en), 32'(exp_on));
        put_word(25'h0222222);
        chk("R6 held lat no reload", 32'(chan_en), 32'(exp_on));
        @(negedge clk);
        lat = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 falling lat no reload", 32'(chan_en), 32'(exp_on));
        strobe();
        exp_on = 24'h222222;
        chk("R6 next rise loads", 32'(chan_en), 32'(exp_on));

        // R7: simultaneous rises
        put_word(25'h0333333);
        @(negedge clk);
        sin = 1'b1; sclk = 1'b1; lat = 1'b1;
        repeat (3) @(negedge clk);
        exp_on = 24'h333333;
        chk("R7 transfer wins", 32'(chan_en), 32'(exp_on));
        sclk = 1'b0; lat = 1'b0;
        repeat (3) @(negedge clk);
        strobe();
        chk("R7 shift dropped", 32'(chan_en), 32'(exp_on));
        chk("R7 flag unchanged", 32'(sout), 32'h0);
        chk("R7 config untouched", 32'(ctrl_q), 32'(exp_cfg));

        // R1: reset mid-run
        put_word(25'h1ABCDEF);
        strobe();
        chk("R5 config before reset", 32'(ctrl_q), 32'hABCDEF);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 mid reset chan_en", 32'(chan_en), 32'h0);
        chk("R1 mid reset ctrl_q", 32'(ctrl_q), 32'h0);
        chk("R1 mid reset sout", 32'(sout), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule